// File: doc/BRIEF.md
# Local Bus Strobe Generator

This block turns one internal bus-cycle request into the active-low control strobes of a 16-bit ISA-style local bus. Each request carries a 24-bit address, a direction, an address space (memory or I/O), a width (8 or 16 bits), a target and the write data. The block registers the request and then runs the bus cycle. For the cycle it drives the address, the byte high enable, the data lanes and the generic read/write strobes. It also drives I/O-only strobes, flash-only strobes, one chip select per target, and the enable for an external data transceiver.

Requests enter through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. While a cycle runs, `req_ready` stays low, so the requester must hold its request or withdraw it. Request fields that change during a busy cycle are ignored. The result of each cycle comes back as a one-clock `done` pulse, which carries the read data. Its consumer has no back-pressure and must take it in that clock.

Top module: `lbus_strobe_gen`

## Requirements
- R1: After reset every strobe, chip select, `bus_bhe_n` and `bus_trde_n` is high, `bus_doe` is 0, `done` is 0 and `req_ready` is 1.
- R2: An accepted cycle has three phases. First comes one setup clock with address and chip select valid and all strobes high. Then comes a command phase of `cfg_cmd_clks` clocks, with 0 treated as 1 and the value sampled at acceptance. Last comes one hold clock with strobes high, during which `done` is 1. The block returns to idle in the following clock.
- R3: `bus_rd_n` is low throughout the command phase of every read, to memory or to I/O. `bus_wr_n` is low throughout the command phase of every write.
- R4: `bus_ior_n` and `bus_iow_n` go low during the command phase only on cycles with `req_io`=1.
- R5: `bus_frd_n` and `bus_fwr_n` go low during the command phase only on memory cycles (`req_io`=0) whose target is the NAND flash (target code 1).
- R6: The target code selects the chip select: 0 selects ROM, 1 selects NAND flash, 2 selects I/O device 0 and 3 selects I/O device 1. Only the matching chip select is low, from setup through hold.
- R7: On reads, `bus_trde_n` follows `bus_rd_n` exactly. On writes, it goes low with `bus_wr_n` and stays low for the single hold clock after `bus_wr_n` rises.
- R8: `bus_bhe_n` is low from setup through hold only on 16-bit cycles. The lanes are chosen as follows. An 8-bit cycle uses lane 0 (bits 7:0) only. A 16-bit cycle with address bit 0 = 0 uses both lanes. A 16-bit cycle with address bit 0 = 1 uses lane 1 (bits 15:8) only. On writes, `bus_doe[i]` is 1 from setup through hold for each used lane, and the lane carries the matching byte of the write data.
- R9: `req_ready` is 1 only while idle. Request fields are captured when the request is accepted, and input changes during a busy cycle do not alter `bus_addr` or the strobes.
- R10: Read data is sampled from `bus_din` on the last command clock and is presented on `rd_data` with `done`. Unused lanes read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd_clks | input | 4 | Command phase length in clocks (0 acts as 1) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 24 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wide | input | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| req_target | input | 2 | Target code (0 ROM, 1 NAND, 2 IO0, 3 IO1) |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | 16 | Read data, valid with done |
| bus_addr | output | 24 | Bus address |
| bus_bhe_n | output | 1 | Byte high enable, active low |
| bus_dout | output | 16 | Bus write data |
| bus_doe | output | 2 | Per-lane data output enable |
| bus_din | input | 16 | Bus read data |
| bus_rd_n | output | 1 | Generic read strobe |
| bus_wr_n | output | 1 | Generic write strobe |
| bus_ior_n | output | 1 | I/O read strobe |
| bus_iow_n | output | 1 | I/O write strobe |
| bus_frd_n | output | 1 | Flash read strobe |
| bus_fwr_n | output | 1 | Flash write strobe |
| rom_cs_n | output | 1 | ROM chip select |
| nand_cs_n | output | 1 | NAND flash chip select |
| io0_cs_n | output | 1 | I/O device 0 chip select |
| io1_cs_n | output | 1 | I/O device 1 chip select |
| bus_trde_n | output | 1 | Transceiver data enable |

## Verification
A request is accepted on edge P0. The setup outputs then appear after P0, the command outputs after P1, the hold outputs (with `done` and `rd_data`) after P(N+1), and idle returns after P(N+2), where N is the effective command length. All outputs decode from registered state, so each one is due one edge after the state changes. The bench drives inputs and samples outputs at falling edges, counts rising edges from acceptance, and checks every output in each phase clock. This includes every command clock, so that the one-clock write tail of the transceiver enable and the command phase length are both pinned.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    TGT_ROM  = 2'd0,
    TGT_NAND = 2'd1,
    TGT_IO0  = 2'd2,
    TGT_IO1  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_CMD   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic              io;
    logic              wide;
    tgt_e              tgt;
    logic [DATA_W-1:0] wdata;
  } req_t;
endpackage

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] cfg_cmd_clks,
  output logic             ready,
  output logic             accept,
  output logic             last_cmd,
  output phase_e           phase
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign ready    = (phase == PH_IDLE);
  assign accept   = ready && req_valid;
  assign last_cmd = (phase == PH_CMD) && (cnt <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (req_valid) begin
          phase <= PH_SETUP;
          cnt   <= (cfg_cmd_clks == '0) ? ONE : cfg_cmd_clks;
        end
        PH_SETUP: phase <= PH_CMD;
        PH_CMD: begin
          if (cnt <= ONE) phase <= PH_HOLD;
          else            cnt   <= cnt - ONE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_setup_then_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SETUP |=> phase == PH_CMD);
  p_hold_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_HOLD |=> ready);
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
endmodule

// File: rtl/lbus_decode.sv
module lbus_decode
  import lbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   wr,
  input  logic   io,
  input  tgt_e   tgt,
  output logic   rd_n,
  output logic   wr_n,
  output logic   ior_n,
  output logic   iow_n,
  output logic   frd_n,
  output logic   fwr_n,
  output logic   rom_cs_n,
  output logic   nand_cs_n,
  output logic   io0_cs_n,
  output logic   io1_cs_n,
  output logic   trde_n
);
  logic in_cycle, in_cmd, in_hold, to_nand;
  logic [3:0] sel;

  assign in_cycle = (phase != PH_IDLE);
  assign in_cmd   = (phase == PH_CMD);
  assign in_hold  = (phase == PH_HOLD);
  assign to_nand  = !io && (tgt == TGT_NAND);

  assign rd_n  = !(in_cmd && !wr);
  assign wr_n  = !(in_cmd &&  wr);
  assign ior_n = !(in_cmd && !wr && io);
  assign iow_n = !(in_cmd &&  wr && io);
  assign frd_n = !(in_cmd && !wr && to_nand);
  assign fwr_n = !(in_cmd &&  wr && to_nand);

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_cs
      assign sel[g] = in_cycle && (tgt == tgt_e'(g));
    end
  endgenerate

  assign rom_cs_n  = !sel[0];
  assign nand_cs_n = !sel[1];
  assign io0_cs_n  = !sel[2];
  assign io1_cs_n  = !sel[3];

  assign trde_n = !(in_cmd || (in_hold && wr));

  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rom_cs_n, ~nand_cs_n, ~io0_cs_n, ~io1_cs_n}));
  p_trde_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle && !wr) |-> (trde_n == rd_n));
  p_trde_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_n) && wr) |-> !trde_n);
  p_io_implies_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ior_n |-> !rd_n);
  p_flash_implies_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fwr_n |-> (!wr_n && ior_n && iow_n));
endmodule

// File: rtl/lbus_lane.sv
module lbus_lane
  import lbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              last_cmd,
  input  logic              a0,
  input  logic              wide,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic              bhe_n,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  doe,
  output logic [DATA_W-1:0] rd_data
);
  logic             active;
  logic [LANES-1:0] lane_en;

  assign active = (phase != PH_IDLE);
  assign bhe_n  = !(active && wide);

  // lane 0 unless a 16-bit cycle starts at an odd byte; upper lanes only when wide
  assign lane_en[0] = !wide || !a0;

  genvar i;
  generate
    for (i = 1; i < LANES; i++) begin : g_en
      assign lane_en[i] = wide;
    end
    for (i = 0; i < LANES; i++) begin : g_lane
      assign dout[8*i +: 8] = lane_en[i] ? wdata[8*i +: 8] : 8'h00;
      assign doe[i]         = active && wr && lane_en[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rd_data[8*i +: 8] <= 8'h00;
        else if (last_cmd && !wr)  rd_data[8*i +: 8] <= lane_en[i] ? din[8*i +: 8] : 8'h00;
      end
    end
  endgenerate

  p_bhe_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (bhe_n && !doe[1]));
  p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> (doe == '0));
endmodule

// File: rtl/lbus_strobe_gen.sv
module lbus_strobe_gen
  import lbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_cmd_clks,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [23:0]       req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_wide,
  input  logic [1:0]        req_target,
  input  logic [15:0]       req_wdata,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic [23:0]       bus_addr,
  output logic              bus_bhe_n,
  output logic [15:0]       bus_dout,
  output logic [1:0]        bus_doe,
  input  logic [15:0]       bus_din,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  output logic              bus_frd_n,
  output logic              bus_fwr_n,
  output logic              rom_cs_n,
  output logic              nand_cs_n,
  output logic              io0_cs_n,
  output logic              io1_cs_n,
  output logic              bus_trde_n
);
  phase_e phase;
  logic   accept, last_cmd;
  req_t   req_q;

  lbus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg_cmd_clks(cfg_cmd_clks),
    .ready(req_ready), .accept(accept), .last_cmd(last_cmd), .phase(phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (accept) begin
      req_q.addr  <= req_addr;
      req_q.wr    <= req_write;
      req_q.io    <= req_io;
      req_q.wide  <= req_wide;
      req_q.tgt   <= tgt_e'(req_target);
      req_q.wdata <= req_wdata;
    end
  end

  assign bus_addr = req_q.addr;
  assign done     = (phase == PH_HOLD);

  lbus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wr(req_q.wr), .io(req_q.io), .tgt(req_q.tgt),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .ior_n(bus_ior_n), .iow_n(bus_iow_n),
    .frd_n(bus_frd_n), .fwr_n(bus_fwr_n), .rom_cs_n(rom_cs_n), .nand_cs_n(nand_cs_n),
    .io0_cs_n(io0_cs_n), .io1_cs_n(io1_cs_n), .trde_n(bus_trde_n)
  );

  lbus_lane u_lane (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last_cmd(last_cmd), .a0(req_q.addr[0]),
    .wide(req_q.wide), .wr(req_q.wr), .wdata(req_q.wdata), .din(bus_din),
    .bhe_n(bus_bhe_n), .dout(bus_dout), .doe(bus_doe), .rd_data(rd_data)
  );

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(accept)) |-> $stable(bus_addr));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_lbus_strobe_gen.sv
module sim_lbus_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_cmd_clks = 4'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic        req_wide = 1'b0;
  logic [1:0]  req_target = 2'd0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rd_data;
  logic [23:0] bus_addr;
  logic        bus_bhe_n;
  logic [15:0] bus_dout;
  logic [1:0]  bus_doe;
  logic [15:0] bus_din = '0;
  logic        bus_rd_n, bus_wr_n, bus_ior_n, bus_iow_n, bus_frd_n, bus_fwr_n;
  logic        rom_cs_n, nand_cs_n, io0_cs_n, io1_cs_n, bus_trde_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lbus_strobe_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cmd_clks(cfg_cmd_clks), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
    .req_wide(req_wide), .req_target(req_target), .req_wdata(req_wdata), .done(done),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_frd_n(bus_frd_n),
    .bus_fwr_n(bus_fwr_n), .rom_cs_n(rom_cs_n), .nand_cs_n(nand_cs_n),
    .io0_cs_n(io0_cs_n), .io1_cs_n(io1_cs_n), .bus_trde_n(bus_trde_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] strobes();
    return {bus_rd_n, bus_wr_n, bus_ior_n, bus_iow_n, bus_frd_n, bus_fwr_n};
  endfunction

  function automatic logic [3:0] selects();
    return {io1_cs_n, io0_cs_n, nand_cs_n, rom_cs_n};
  endfunction

  // One full bus cycle; inputs driven and outputs sampled at falling edges.
  task automatic run_cycle(logic [23:0] a, logic wr, logic io, logic wide, logic [1:0] tgt,
                           logic [15:0] wd, logic [15:0] din, logic [3:0] ncfg);
    int n = (ncfg == 0) ? 1 : int'(ncfg);
    logic [1:0]  lanes = {wide, (!wide || !a[0])};
    logic [15:0] lmask = {{8{lanes[1]}}, {8{lanes[0]}}};
    logic [3:0]  cs_exp = ~(4'b0001 << tgt);
    logic [5:0]  cmd_exp = ~{!wr, wr, !wr && io, wr && io,
                             !wr && !io && tgt == 2'd1, wr && !io && tgt == 2'd1};
    @(negedge clk);
    check("R9 ready idle", {31'd0, req_ready}, 32'd1);
    req_addr = a; req_write = wr; req_io = io; req_wide = wide; req_target = tgt;
    req_wdata = wd; bus_din = din; cfg_cmd_clks = ncfg; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // garbage while busy, valid kept high: must be ignored (R9)
    req_addr = ~a; req_write = !wr; req_io = !io; req_target = tgt + 2'd1;
    req_wdata = ~wd; cfg_cmd_clks = 4'd9;
    check("R9 busy ready low", {31'd0, req_ready}, 32'd0);
    check("R2 setup strobes high", {26'd0, strobes()}, 32'h3f);
    check("R6 setup chip select", {28'd0, selects()}, {28'd0, cs_exp});
    check("R7 setup trde high", {31'd0, bus_trde_n}, 32'd1);
    check("R8 bhe", {31'd0, bus_bhe_n}, {31'd0, !wide});
    check("R9 addr", {8'd0, bus_addr}, {8'd0, a});
    check("R8 doe", {30'd0, bus_doe}, {30'd0, wr ? lanes : 2'b00});
    if (wr) check("R8 dout", {16'd0, bus_dout & lmask}, {16'd0, wd & lmask});
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R3 R4 R5 command strobes", {26'd0, strobes()}, {26'd0, cmd_exp});
      check("R7 trde in command", {31'd0, bus_trde_n}, 32'd0);
      check("R6 cmd chip select", {28'd0, selects()}, {28'd0, cs_exp});
      check("R2 no done in command", {31'd0, done}, 32'd0);
      check("R9 addr held", {8'd0, bus_addr}, {8'd0, a});
    end
    @(negedge clk);
    check("R2 hold done", {31'd0, done}, 32'd1);
    check("R2 hold strobes high", {26'd0, strobes()}, 32'h3f);
    check("R7 hold trde", {31'd0, bus_trde_n}, {31'd0, !wr});
    check("R6 hold chip select", {28'd0, selects()}, {28'd0, cs_exp});
    check("R8 hold bhe", {31'd0, bus_bhe_n}, {31'd0, !wide});
    if (!wr) check("R10 read data", {16'd0, rd_data}, {16'd0, din & lmask});
    req_valid = 1'b0;
    @(negedge clk);
    check("R2 back to idle", {31'd0, req_ready}, 32'd1);
    check("R2 idle selects", {28'd0, selects()}, 32'hf);
    check("R7 idle trde", {31'd0, bus_trde_n}, 32'd1);
    check("R2 done single", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 strobes", {26'd0, strobes()}, 32'h3f);
    check("R1 selects", {28'd0, selects()}, 32'hf);
    check("R1 trde bhe", {30'd0, bus_trde_n, bus_bhe_n}, 32'd3);
    check("R1 doe done ready", {28'd0, bus_doe, done, req_ready}, 32'd1);
  endtask

  task automatic t_rom_read8;       run_cycle(24'h001235, 0, 0, 0, 2'd0, 16'h0000, 16'hA55A, 4'd1); endtask
  task automatic t_nand_write16;    run_cycle(24'h400010, 1, 0, 1, 2'd1, 16'hBEEF, 16'h0000, 4'd3); endtask
  task automatic t_nand_read_long;  run_cycle(24'h400022, 0, 0, 1, 2'd1, 16'h0000, 16'h1234, 4'd5); endtask
  task automatic t_io0_read_odd;    run_cycle(24'h000301, 0, 1, 1, 2'd2, 16'h0000, 16'hC3D4, 4'd2); endtask
  task automatic t_io1_write8;      run_cycle(24'h000380, 1, 1, 0, 2'd3, 16'h5A7E, 16'h0000, 4'd2); endtask
  task automatic t_zero_cfg_write;  run_cycle(24'h0000F0, 1, 0, 0, 2'd0, 16'h00C1, 16'h0000, 4'd0); endtask
  task automatic t_io_write_odd16;  run_cycle(24'h000201, 1, 1, 1, 2'd2, 16'h9A3C, 16'h0000, 4'd1); endtask

  task automatic t_idle_no_request;
    repeat (3) @(negedge clk);
    check("R9 no request no cycle", {27'd0, req_ready, selects()}, 32'h1f);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_no_request();
    t_rom_read8();
    t_nand_write16();
    t_nand_read_long();
    t_io0_read_odd();
    t_io1_write8();
    t_zero_cfg_write();
    t_io_write_odd16();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule